// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher and Interrupt Flags

This block sits beside a real-time clock's time-of-day counter. At the end of each one-second update it compares the current seconds, minutes and hours with three host-programmed alarm bytes. The result, together with the update-ended and periodic events, is recorded as sticky flags in a status byte. An active-high interrupt line is driven from those flags, and each source has its own enable bit.

The host writes the alarm bytes and the enable byte through a small write port. It reads the status byte on `statData`, which is always visible. It pulses `statRd` to consume the flags. The time counter and the periodic rate divider are outside this block: they supply `curSec`, `curMin`, `curHour`, the one-cycle `updDone` pulse and the one-cycle `perTick` pulse.

Top module: `alarmFlags`

## Requirements
- R1: After reset, `statData` is 0x00 and `irq` is 0. All alarm bytes and enable bits are 0.
- R2: A write with `wrEn` high loads `wrData` by `wrAddr`: 0 is the seconds alarm, 1 is the minutes alarm, 2 is the hours alarm, 3 is the enable byte. When `updDone` is high and all three fields equal their alarm bytes, the alarm flag (`statData` bit 5) is 1 from the next cycle.
- R3: An alarm byte whose bits 7 and 6 are both 1 matches any value of its field.
- R4: The hour compare covers all 8 bits, including the PM bit 7. Hours that differ only in bit 7 give no alarm.
- R5: The alarm flag is set only in a cycle with `updDone`. Writing an alarm byte that equals the current time does not set it.
- R6: Every `updDone` pulse sets the update flag (`statData` bit 4) from the next cycle.
- R7: Every `perTick` pulse sets the periodic flag (`statData` bit 6) from the next cycle.
- R8: Enable byte bit 0 enables periodic, bit 1 enables alarm and bit 2 enables update. `statData` bit 7 and `irq` are 1 exactly when some flag is set with its enable set. Bits 3:0 read 0.
- R9: A cycle with `statRd` high clears all flags. The read returns the flags as they were, and a following read returns 0x00.
- R10: A flag whose setting event falls in the same cycle as `statRd` is kept and shows at the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| curSec | input | 8 | Current seconds from the time counter |
| curMin | input | 8 | Current minutes from the time counter |
| curHour | input | 8 | Current hours, bit 7 is PM in 12-hour mode |
| updDone | input | 1 | One-cycle pulse at the end of a time update |
| perTick | input | 1 | One-cycle periodic event |
| wrEn | input | 1 | Host register write strobe |
| wrAddr | input | 2 | Write register select |
| wrData | input | 8 | Write data |
| statRd | input | 1 | Status read strobe; clears the flags |
| statData | output | 8 | Status byte: interrupt, periodic, alarm, update flags |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest case to reach is a flag event in the same cycle as a status read. This event must survive the clear. The bench raises `statRd` and `updDone` in the same driven cycle and then expects the update flag alone on the next read. The PM-only hour mismatch also needs care. The bench programs an hour alarm with bit 7 set, presents the same hour without it, and then presents it with bit 7 set to show that the compare is not simply blind.

// File: rtl/rtcAlarmPkg.sv
package rtcAlarmPkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 3;
  localparam int EN_W       = 3;
  localparam int ADDR_W     = 2;
  localparam int EN_ADDR    = NUM_FIELDS;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] ldAlarm;
    logic                  ldEn;
    logic                  clrFlags;
  } ctlStrobes_t;
endpackage

// File: rtl/alarmCtl.sv
module alarmCtl
  import rtcAlarmPkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              statRd,
  output ctlStrobes_t       strobes
);
  always_comb begin
    strobes = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      strobes.ldAlarm[i] = wrEn && (wrAddr == ADDR_W'(i));
    strobes.ldEn     = wrEn && (wrAddr == ADDR_W'(EN_ADDR));
    strobes.clrFlags = statRd;
  end
endmodule

// File: rtl/alarmDatapath.sv
module alarmDatapath
  import rtcAlarmPkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  ctlStrobes_t                         strobes,
  input  logic [FIELD_W-1:0]                  wrData,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  curTime,
  input  logic                                updDone,
  input  logic                                perTick,
  output logic [7:0]                          statData,
  output logic                                irq
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] almReg;
  logic [NUM_FIELDS-1:0]              fieldHit;
  logic [EN_W-1:0]                    enReg;
  logic                               afFlag, ufFlag, pfFlag;
  logic                               allHit, irqFlag;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : gField
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   almReg[i] <= '0;
      else if (strobes.ldAlarm[i]) almReg[i] <= wrData;
    end
    assign fieldHit[i] = (almReg[i][FIELD_W-1 -: 2] == 2'b11) ||
                         (almReg[i] == curTime[i]);
  end

  assign allHit = &fieldHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= '0;
      afFlag <= 1'b0;
      ufFlag <= 1'b0;
      pfFlag <= 1'b0;
    end else begin
      if (strobes.ldEn) enReg <= wrData[EN_W-1:0];
      afFlag <= (afFlag && !strobes.clrFlags) || (updDone && allHit);
      ufFlag <= (ufFlag && !strobes.clrFlags) || updDone;
      pfFlag <= (pfFlag && !strobes.clrFlags) || perTick;
    end
  end

  assign irqFlag  = (pfFlag && enReg[0]) || (afFlag && enReg[1]) || (ufFlag && enReg[2]);
  assign statData = {irqFlag, pfFlag, afFlag, ufFlag, 4'b0000};
  assign irq      = irqFlag;
endmodule

// File: rtl/alarmFlags.sv
module alarmFlags
  import rtcAlarmPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        curSec,
  input  logic [7:0]        curMin,
  input  logic [7:0]        curHour,
  input  logic              updDone,
  input  logic              perTick,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic              statRd,
  output logic [7:0]        statData,
  output logic              irq
);
  ctlStrobes_t strobes;

  alarmCtl uCtl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .statRd  (statRd),
    .strobes (strobes)
  );

  alarmDatapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .curTime  ({curHour, curMin, curSec}),
    .updDone  (updDone),
    .perTick  (perTick),
    .statData (statData),
    .irq      (irq)
  );
endmodule

// File: rtl/alarmFlagsChk.sv
module alarmFlagsChk (
  input logic       clk,
  input logic       rstN,
  input logic       updDone,
  input logic       perTick,
  input logic       wrEn,
  input logic       statRd,
  input logic [7:0] statData,
  input logic       irq
);
  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rstN) |-> (statData == 8'h00 && !irq)); // R1
  AST_AF_ON_UPDATE: assert property (@(posedge clk) disable iff (!rstN) $rose(statData[5]) |-> $past(updDone)); // R5
  AST_UF_SET: assert property (@(posedge clk) disable iff (!rstN) updDone |=> statData[4]); // R6
  AST_PF_SET: assert property (@(posedge clk) disable iff (!rstN) perTick |=> statData[6]); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN) $rose(irq) |-> $past(updDone || perTick || wrEn)); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN) (statRd && !updDone && !perTick) |=> (statData == 8'h00)); // R9
  AST_KEEP_ON_READ: assert property (@(posedge clk) disable iff (!rstN) (statRd && updDone) |=> statData[4]); // R10
endmodule

bind alarmFlags alarmFlagsChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .updDone  (updDone),
  .perTick  (perTick),
  .wrEn     (wrEn),
  .statRd   (statRd),
  .statData (statData),
  .irq      (irq)
);

// File: tb/alarmFlags_test.sv
module alarmFlags_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0;
  logic       updDone = 1'b0, perTick = 1'b0, wrEn = 1'b0, statRd = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] statData;
  logic       irq;
  int         nChecks = 0;
  int         nFails = 0;

  always #5 clk = ~clk;

  alarmFlags uut (
    .clk(clk), .rstN(rstN), .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .updDone(updDone), .perTick(perTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .statRd(statRd), .statData(statData), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic update(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    curHour = h; curMin = m; curSec = s; updDone = 1'b1;
    tick();
    updDone = 1'b0;
  endtask

  task automatic readStat(input string req, input logic [7:0] exp);
    chk(req, statData, exp);
    statRd = 1'b1;
    tick();
    statRd = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 status", statData, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic testMatch();
    wr(2'd0, 8'h45); wr(2'd1, 8'h30); wr(2'd2, 8'h12);
    update(8'h12, 8'h30, 8'h45);
    readStat("R2 match sets AF, R6 UF", 8'h30);
    readStat("R9 second read empty", 8'h00);
    update(8'h12, 8'h31, 8'h45);
    readStat("R2 minute mismatch, R6 UF only", 8'h10);
  endtask

  task automatic testWildcard();
    wr(2'd0, 8'hC0); wr(2'd1, 8'hC5); wr(2'd2, 8'h12);
    update(8'h12, 8'h22, 8'h07);
    readStat("R3 wildcard sec and min", 8'h30);
    update(8'h11, 8'h22, 8'h07);
    readStat("R3 hour still compared", 8'h10);
  endtask

  task automatic testPm();
    wr(2'd2, 8'h82);
    update(8'h02, 8'h00, 8'h00);
    readStat("R4 PM-only difference", 8'h10);
    update(8'h82, 8'h00, 8'h00);
    readStat("R4 PM hour matches", 8'h30);
  endtask

  task automatic testNoUpdate();
    curHour = 8'h05; curMin = 8'h06; curSec = 8'h07;
    wr(2'd0, 8'h07); wr(2'd1, 8'h06); wr(2'd2, 8'h05);
    tick(); tick();
    chk("R5 write alone sets nothing", statData, 8'h00);
  endtask

  task automatic testPeriodic();
    perTick = 1'b1; tick(); perTick = 1'b0;
    readStat("R7 periodic flag", 8'h40);
  endtask

  task automatic testIrq();
    update(8'h05, 8'h06, 8'h07);
    chk("R8 no enable no irq", {7'b0, irq}, 8'h00);
    chk("R8 no enable status", statData, 8'h30);
    wr(2'd3, 8'h02);
    chk("R8 alarm enable irq", {7'b0, irq}, 8'h01);
    readStat("R8 status with irq bit", 8'hB0);
    chk("R9 read drops irq", {7'b0, irq}, 8'h00);
    wr(2'd3, 8'h04);
    update(8'h01, 8'h01, 8'h01);
    chk("R8 update enable irq", {7'b0, irq}, 8'h01);
    readStat("R8 update irq status", 8'h90);
    wr(2'd3, 8'h01);
    perTick = 1'b1; tick(); perTick = 1'b0;
    chk("R8 periodic enable irq", {7'b0, irq}, 8'h01);
    readStat("R8 periodic irq status", 8'hC0);
    wr(2'd3, 8'h00);
  endtask

  task automatic testSameCycle();
    perTick = 1'b1; tick(); perTick = 1'b0;
    chk("R10 setup", statData, 8'h40);
    curHour = 8'h00; curMin = 8'h00; curSec = 8'h00;
    statRd = 1'b1; updDone = 1'b1;
    tick();
    statRd = 1'b0; updDone = 1'b0;
    readStat("R10 update kept across read", 8'h10);
    readStat("R9 cleared afterwards", 8'h00);
  endtask

  initial begin
    #1;
    tick();
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testMatch();
    testWildcard();
    testPm();
    testNoUpdate();
    testPeriodic();
    testIrq();
    testSameCycle();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule